// File: doc/BRIEF.md
# Selectable Register Arithmetic Circuit

This block is the arithmetic slice of a small datapath. It builds every result from one adder. The first adder operand is always A. The second operand, called Y here, comes from a two-bit operand select that picks one of four sources: B, the bitwise inverse of B, all zeros or all ones. A separate carry input is added on top. The four Y sources and the two carry-in values give eight operations from the same adder: add, add with carry, subtract with borrow, subtract, transfer, increment, decrement, and a second transfer.

In the default build, the sum and the carry out of the top bit pass through an output register. The register captures only on a clock edge where the load strobe is high. It clears synchronously. With a parameter, the register can be removed, which leaves a purely combinational unit. A second parameter picks the adder: an explicit ripple chain of full-adder cells, or a single native addition that the synthesis tool maps.

Top module: `sel_arith_unit`

## Requirements
- R1: With sel_i = 2'b00, Y = B and the result is (A + B + cin_i) mod 2^N.
- R2: With sel_i = 2'b01, Y = ~B. With cin_i = 1 the result is A - B mod 2^N, and the carry out is 1 exactly when A >= B unsigned. With cin_i = 0 the result is A + ~B (A - B - 1).
- R3: With sel_i = 2'b10, Y = 0. With cin_i = 0 the result is A and the carry out is 0. With cin_i = 1 the result is A + 1, and the carry out is 1 only when A is all ones.
- R4: With sel_i = 2'b11 and cin_i = 0, Y is all ones and the result is A - 1 mod 2^N. The carry out is 1 for every A except zero.
- R5: With sel_i = 2'b11 and cin_i = 1, the result equals A and the carry out is 1.
- R6: The carry out is bit N of the (N+1)-bit sum A + Y + cin_i.
- R7: With the output register present, res_o and cout_o take the new sum on the rising edge where load_i is 1. Both hold their value on every edge where load_i is 0.
- R8: A synchronous active-high rst_i clears res_o and cout_o to zero on the next rising edge, even when load_i is 1.
- R9: All arithmetic wraps modulo 2^N. For example, all ones plus one gives zero with a carry out of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_i | input | 1 | Synchronous active-high reset of the output register |
| load_i | input | 1 | Capture strobe for the output register |
| sel_i | input | 2 | Second-operand select (00 B, 01 ~B, 10 zero, 11 all ones) |
| cin_i | input | 1 | Carry input added into the sum |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Source operand for the second adder input |
| res_o | output | WIDTH | Result, registered by default |
| cout_o | output | 1 | Carry out of the top bit, registered by default |

## Verification
The bench targets the codes whose results depend on the carry chain wrapping:
- Decrement of zero must give all ones with no carry. A design with the inverted Y source miswired would return one or set the carry.
- Code 11 with carry-in 1 must give back A with a carry. A design that treated this code as unused would give A - 1 or zero instead.
- Subtract with equal operands, and with A below B, must give the correct borrow sense in the carry. A design that dropped carry-in on that path would be one off.
- The register tests cover two cases. With load low, the output must hold while the inputs change, so a register that captured on every edge would follow the inputs. With reset and load high together, the output must be zero, so a design that gave load priority over reset would show the sum instead.

// File: rtl/sel_arith_pkg.sv
package sel_arith_pkg;

   // Second-operand source codes; the encoding is the external select contract.
   typedef enum logic [1:0] {
      YSEL_B    = 2'b00,
      YSEL_NOTB = 2'b01,
      YSEL_ZERO = 2'b10,
      YSEL_ONES = 2'b11
   } ysel_e;

   // Adder implementation choices.
   localparam int ADDER_RIPPLE = 0;
   localparam int ADDER_NATIVE = 1;

endpackage

// File: rtl/sel_arith_fa.sv
module sel_arith_fa (
   input  logic x_i,
   input  logic y_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);

   logic half_s;

   assign half_s = x_i ^ y_i;
   assign s_o    = half_s ^ c_i;
   assign c_o    = (x_i & y_i) | (half_s & c_i);

endmodule

// File: rtl/sel_arith_ymux.sv
module sel_arith_ymux
   import sel_arith_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  ysel_e              sel_i,
   input  logic [WIDTH-1:0]   b_i,
   output logic [WIDTH-1:0]   y_o
);

   localparam logic [WIDTH-1:0] ALL_ZERO = '0;
   localparam logic [WIDTH-1:0] ALL_ONES = '1;

   always_comb begin
      unique case (sel_i)
         YSEL_B:    y_o = b_i;
         YSEL_NOTB: y_o = ~b_i;
         YSEL_ZERO: y_o = ALL_ZERO;
         YSEL_ONES: y_o = ALL_ONES;
         default:   y_o = ALL_ZERO;
      endcase
   end

endmodule

// File: rtl/sel_arith_adder.sv
module sel_arith_adder
   import sel_arith_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter int ADDER_KIND = ADDER_RIPPLE
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);

   localparam int SUM_W = WIDTH + 1;

   generate
      if (ADDER_KIND == ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = cin_i;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            sel_arith_fa i_fa (
               .x_i (a_i[i]),
               .y_i (y_i[i]),
               .c_i (chain[i]),
               .s_o (sum_o[i]),
               .c_o (chain[i+1])
            );
         end
         assign cout_o = chain[WIDTH];

         // Cross-check of the cell chain against a wide addition.
         always_comb begin
            if (!$isunknown({a_i, y_i, cin_i})) begin
               AST_CARRY_IS_TOP_BIT: assert ({cout_o, sum_o} ==
                  (SUM_W'(a_i) + SUM_W'(y_i) + SUM_W'(cin_i)))
                  else $error("ripple chain disagrees with sum"); // R6
            end
         end
      end else begin : g_native
         logic [SUM_W-1:0] wide;
         assign wide   = SUM_W'(a_i) + SUM_W'(y_i) + SUM_W'(cin_i);
         assign sum_o  = wide[WIDTH-1:0];
         assign cout_o = wide[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/sel_arith_outreg.sv
module sel_arith_outreg #(
   parameter int WIDTH   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             load_i,
   input  logic [WIDTH-1:0] d_i,
   input  logic             c_i,
   output logic [WIDTH-1:0] q_o,
   output logic             cq_o
);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               q_o  <= '0;
               cq_o <= 1'b0;
            end else if (load_i) begin
               q_o  <= d_i;
               cq_o <= c_i;
            end
         end

         AST_LOAD_CAPTURES: assert property (@(posedge clk_i) disable iff (rst_i)
            load_i |=> (q_o == $past(d_i)) && (cq_o == $past(c_i))); // R7
         AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
            !load_i |=> $stable(q_o) && $stable(cq_o)); // R7
         AST_RESET_CLEARS: assert property (@(posedge clk_i)
            rst_i |=> (q_o == '0) && !cq_o); // R8
      end else begin : g_pass
         assign q_o  = d_i;
         assign cq_o = c_i;
      end
   endgenerate

endmodule

// File: rtl/sel_arith_unit.sv
module sel_arith_unit
   import sel_arith_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter int ADDER_KIND = ADDER_RIPPLE,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             load_i,
   input  logic [1:0]       sel_i,
   input  logic             cin_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] res_o,
   output logic             cout_o
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("WIDTH must be at least 1");
      end
      if (ADDER_KIND != ADDER_RIPPLE && ADDER_KIND != ADDER_NATIVE) begin : g_bad_kind
         $error("ADDER_KIND must select ripple or native");
      end
   endgenerate

   ysel_e            ysel;
   logic [WIDTH-1:0] y_opnd;
   logic [WIDTH-1:0] sum;
   logic             carry;

   assign ysel = ysel_e'(sel_i);

   sel_arith_ymux #(.WIDTH(WIDTH)) i_ymux (
      .sel_i (ysel),
      .b_i   (b_i),
      .y_o   (y_opnd)
   );

   sel_arith_adder #(.WIDTH(WIDTH), .ADDER_KIND(ADDER_KIND)) i_adder (
      .a_i    (a_i),
      .y_i    (y_opnd),
      .cin_i  (cin_i),
      .sum_o  (sum),
      .cout_o (carry)
   );

   sel_arith_outreg #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) i_outreg (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .load_i (load_i),
      .d_i    (sum),
      .c_i    (carry),
      .q_o    (res_o),
      .cq_o   (cout_o)
   );

   generate
      if (REG_OUT) begin : g_port_checks
         AST_WRAP_TRANSFER: assert property (@(posedge clk_i) disable iff (rst_i)
            (load_i && sel_i == 2'b11 && cin_i) |=> (res_o == $past(a_i)) && cout_o); // R5
         AST_PLAIN_TRANSFER: assert property (@(posedge clk_i) disable iff (rst_i)
            (load_i && sel_i == 2'b10 && !cin_i) |=> (res_o == $past(a_i)) && !cout_o); // R3
         AST_DECR_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
            (load_i && sel_i == 2'b11 && !cin_i && a_i == '0) |=> (res_o == '1) && !cout_o); // R4
      end
   endgenerate

endmodule

// File: tb/test_sel_arith_unit.sv
module test_sel_arith_unit;

   localparam int W  = 8;
   localparam int NV = 15;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         load = 1'b0;
   logic [1:0]   sel = 2'b00;
   logic         cin = 1'b0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic [W-1:0] res;
   logic         cout;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   sel_arith_unit #(.WIDTH(W)) i_sel_arith_unit (
      .clk_i (clk), .rst_i (rst), .load_i (load), .sel_i (sel), .cin_i (cin),
      .a_i (a), .b_i (b), .res_o (res), .cout_o (cout)
   );

   // {sel, cin, a, b, expected result, expected carry, requirement number}
   localparam logic [31:0] VEC [NV] = '{
      {2'b00, 1'b0, 8'h12, 8'h34, 8'h46, 1'b0, 4'd1},  // R1 add
      {2'b00, 1'b1, 8'h12, 8'h34, 8'h47, 1'b0, 4'd1},  // R1 add with carry
      {2'b00, 1'b0, 8'hFF, 8'h01, 8'h00, 1'b1, 4'd9},  // R9 wrap
      {2'b00, 1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b1, 4'd6},  // R6 full carry
      {2'b01, 1'b1, 8'h50, 8'h20, 8'h30, 1'b1, 4'd2},  // R2 subtract, A>=B
      {2'b01, 1'b1, 8'h20, 8'h50, 8'hD0, 1'b0, 4'd2},  // R2 subtract, A<B
      {2'b01, 1'b0, 8'h50, 8'h20, 8'h2F, 1'b1, 4'd2},  // R2 subtract with borrow
      {2'b01, 1'b1, 8'h33, 8'h33, 8'h00, 1'b1, 4'd2},  // R2 equal operands
      {2'b10, 1'b0, 8'hA5, 8'h5A, 8'hA5, 1'b0, 4'd3},  // R3 transfer
      {2'b10, 1'b1, 8'hA5, 8'h5A, 8'hA6, 1'b0, 4'd3},  // R3 increment
      {2'b10, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 4'd3},  // R3 increment wraps
      {2'b11, 1'b0, 8'h10, 8'h77, 8'h0F, 1'b1, 4'd4},  // R4 decrement
      {2'b11, 1'b0, 8'h00, 8'h77, 8'hFF, 1'b0, 4'd4},  // R4 decrement of zero
      {2'b11, 1'b1, 8'h7E, 8'h11, 8'h7E, 1'b1, 4'd5},  // R5 second transfer
      {2'b11, 1'b1, 8'h00, 8'hFF, 8'h00, 1'b1, 4'd5}   // R5 second transfer of zero
   };

   function automatic logic [W:0] model(input logic [1:0] s, input logic c,
                                        input logic [W-1:0] x, input logic [W-1:0] z);
      logic [W-1:0] y;
      case (s)
         2'b00:   y = z;
         2'b01:   y = ~z;
         2'b10:   y = '0;
         default: y = '1;
      endcase
      return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
   endfunction

   task automatic check(input string tag, input logic [W-1:0] exp_d, input logic exp_c);
      checks++;
      if (res !== exp_d || cout !== exp_c) begin
         fails++;
         $display("FAIL %s: got res=%h cout=%b, expected res=%h cout=%b",
                  tag, res, cout, exp_d, exp_c);
      end
   endtask

   task automatic apply(input logic [1:0] s, input logic c,
                        input logic [W-1:0] x, input logic [W-1:0] z);
      @(negedge clk);
      sel = s; cin = c; a = x; b = z; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R8 reset state", 8'h00, 1'b0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][31:30], VEC[i][29], VEC[i][28:21], VEC[i][20:13]);
         check($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][12:5], VEC[i][4]);
      end

      // R6: every code against a spread of operands from the requirement model
      for (int s = 0; s < 4; s++) begin
         for (int c = 0; c < 2; c++) begin
            for (int k = 0; k < 4; k++) begin
               logic [W-1:0] x;
               logic [W-1:0] z;
               logic [W:0]   e;
               x = W'(k * 8'h47 + 8'h0B);
               z = W'(k * 8'h3D + 8'hC2);
               e = model(2'(s), 1'(c), x, z);
               apply(2'(s), 1'(c), x, z);
               check("R6 model sweep", e[W-1:0], e[W]);
            end
         end
      end

      // R7: load low holds the value while inputs move
      apply(2'b00, 1'b0, 8'h0F, 8'h01);
      check("R7 load value", 8'h10, 1'b0);
      @(negedge clk);
      sel = 2'b11; cin = 1'b0; a = 8'h00; b = 8'hFF;
      repeat (2) @(negedge clk);
      check("R7 hold with load low", 8'h10, 1'b0);

      // R8: reset wins over load
      @(negedge clk);
      sel = 2'b00; cin = 1'b1; a = 8'h40; b = 8'h40; load = 1'b1; rst = 1'b1;
      @(negedge clk);
      check("R8 reset over load", 8'h00, 1'b0);
      rst = 1'b0;
      @(negedge clk);
      load = 1'b0;
      check("R1 load after reset", 8'h81, 1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule